// File: doc/BRIEF.md
# Endpoint Interrupt Clear Sequencer

This block keeps the per-endpoint interrupt state of a device controller that has 16 logical endpoints, each split into a receive and a transmit physical endpoint, for 32 in all. An event on a physical endpoint is routed by that endpoint's enable bit. It goes either to the interrupt status vector, which serves the slave path, or to the DMA-request status vector. A single combined interrupt line reports whether any status bit is set.

Software clears interrupts through a write-only clear vector. Each bit written as one becomes a pending select/clear command. The sequencer issues these commands one at a time to the serial interface engine over a request/acknowledge port and receives an endpoint status byte for each one. While commands are outstanding, the command-data-full flag is low. It rises once the last pending command has finished. At that point the command data register holds the status byte of the lowest-numbered endpoint served in the sequence.

Top module: `ep_irq_clear_seq`

## Requirements
- R1: Bit index 2n of every endpoint vector is the receive endpoint of logical endpoint n, and bit 2n+1 is its transmit endpoint. An `ep_event` pulse on bit i with `ep_int_en[i]`=1 sets `irq_status[i]` one clock later.
- R2: An `ep_event` pulse on bit i with `ep_int_en[i]`=0 sets `dma_req_status[i]` one clock later and leaves `irq_status[i]` unchanged.
- R3: After reset, `ep_int_en`, `irq_status`, `dma_req_status`, `cmd_data_full` and `sie_req` are all zero. A write on `en_wr` loads the whole enable vector. `clr_rdata` always reads zero.
- R4: Each bit written as 1 through `clr_wr` produces exactly one request on `sie_req` with `sie_ep_idx` equal to that bit's index. A write of all zeros has no effect on the flag, the requests or the status.
- R5: A clear write with any bit set drives `cmd_data_full` to 0 on the same clock edge. The flag goes back to 1 on the edge that accepts the acknowledge of the last pending command.
- R6: On the edge where `sie_ack` is seen with `sie_req` high, the served endpoint's bit in `irq_status` is cleared.
- R7: Pending commands are served in ascending index order, with one handshake per endpoint. After a multi-bit clear, `cmd_data` holds the `sie_status` byte returned for the lowest index that was served.
- R8: A clear write that arrives during a running sequence ORs its bits into the pending set. The sequence is not restarted, the new bits are served in index order with the remaining ones, and `cmd_data_full` stays 0 until all of them are done.
- R9: If an enabled event arrives on the same edge that clears the endpoint's status bit, the bit stays set.
- R10: `irq_out` is 1 exactly when at least one `irq_status` bit is set.
- R11: `sie_req` stays high with a stable `sie_ep_idx` until `sie_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ep_event | input | 32 | Single-cycle endpoint event pulses |
| en_wr | input | 1 | Write strobe for the enable vector |
| en_wdata | input | 32 | New enable vector |
| clr_wr | input | 1 | Write strobe for the clear vector |
| clr_wdata | input | 32 | Clear bits, one per physical endpoint |
| clr_rdata | output | 32 | Read value of the clear vector (always zero) |
| sie_req | output | 1 | Select/clear command request |
| sie_ep_idx | output | 5 | Physical endpoint of the current command |
| sie_ack | input | 1 | Command acknowledge, one cycle |
| sie_status | input | 8 | Endpoint status byte, valid with sie_ack |
| ep_int_en | output | 32 | Enable vector |
| irq_status | output | 32 | Slave-mode interrupt status |
| dma_req_status | output | 32 | DMA-request status |
| cmd_data_full | output | 1 | Command completion flag |
| cmd_data | output | 8 | Command data register |
| irq_out | output | 1 | OR of all interrupt status bits |

## Verification
Event routing and the enable load show up one edge after the stimulus, and the bench samples them at the following falling edge. The flag drop is due on the edge of the clear write. A new request rises one edge after the pending set becomes non-empty, and the flag, the status bit and `cmd_data` all change on the acknowledge edge. The bench's acknowledge responder logs every served index. Completion is detected by polling at falling edges until the flag is high with no request open, and order and data are then compared with values the bench computes itself from the requirements.

// File: rtl/ep_irq_pkg.sv
package ep_irq_pkg;
  parameter int unsigned SIE_STAT_W = 8;
  typedef logic [SIE_STAT_W-1:0] sie_stat_t;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/ep_irq_status_regs.sv
module ep_irq_status_regs #(
  parameter int unsigned NUM_EP = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_event,
  input  logic              en_wr,
  input  logic [NUM_EP-1:0] en_wdata,
  input  logic [NUM_EP-1:0] clr_vec,
  output logic [NUM_EP-1:0] irq_status,
  output logic [NUM_EP-1:0] dma_req_status,
  output logic [NUM_EP-1:0] ep_int_en
);
  logic [NUM_EP-1:0] slave_hits;
  logic [NUM_EP-1:0] dma_hits;

  assign slave_hits = ep_event & ep_int_en;
  assign dma_hits   = ep_event & ~ep_int_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ep_int_en      <= '0;
      irq_status     <= '0;
      dma_req_status <= '0;
    end else begin
      if (en_wr) ep_int_en <= en_wdata;
      // a new event outranks a clear on the same edge
      irq_status     <= (irq_status & ~clr_vec) | slave_hits;
      dma_req_status <= dma_req_status | dma_hits;
    end
  end
endmodule

// File: rtl/ep_clr_pending.sv
module ep_clr_pending #(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_wr,
  input  logic [NUM_EP-1:0] clr_wdata,
  input  logic [NUM_EP-1:0] done_vec,
  output logic [NUM_EP-1:0] pending,
  output logic              any_pending,
  output logic [IDX_W-1:0]  low_idx,
  output logic              last_one
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [NUM_EP-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NUM_EP - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [NUM_EP-1:0] remain;
  logic [NUM_EP-1:0] added;

  assign remain      = pending & ~done_vec;
  assign added       = clr_wr ? clr_wdata : '0;
  assign any_pending = |pending;
  assign low_idx     = lowest_set(pending);
  assign last_one    = ~|remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= remain | added;
  end
endmodule

// File: rtl/ep_sie_cmd_fsm.sv
module ep_sie_cmd_fsm
  import ep_irq_pkg::*;
#(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_EP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             any_pending,
  input  logic [IDX_W-1:0] low_idx,
  input  logic             last_one,
  input  logic             wr_nonzero,
  input  logic             sie_ack,
  input  sie_stat_t        sie_status,
  output logic             sie_req,
  output logic [IDX_W-1:0] sie_ep_idx,
  output logic             done_pulse,
  output logic             cmd_data_full,
  output sie_stat_t        cmd_data
);
  seq_state_t       st;
  logic             cap_valid;
  logic [IDX_W-1:0] cap_idx;
  logic             seq_end;
  logic             take_status;

  assign done_pulse  = (st == SEQ_BUSY) && sie_ack;
  assign seq_end     = done_pulse && last_one && !wr_nonzero;
  assign take_status = done_pulse && (!cap_valid || (sie_ep_idx < cap_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= SEQ_IDLE;
      sie_req    <= 1'b0;
      sie_ep_idx <= '0;
    end else begin
      case (st)
        SEQ_IDLE: if (any_pending) begin
          st         <= SEQ_BUSY;
          sie_req    <= 1'b1;
          sie_ep_idx <= low_idx;
        end
        SEQ_BUSY: if (sie_ack) begin
          st      <= SEQ_IDLE;
          sie_req <= 1'b0;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_data_full <= 1'b0;
      cmd_data      <= '0;
      cap_valid     <= 1'b0;
      cap_idx       <= '0;
    end else begin
      if (wr_nonzero)   cmd_data_full <= 1'b0;
      else if (seq_end) cmd_data_full <= 1'b1;
      if (take_status) begin
        cmd_data <= sie_status;
        cap_idx  <= sie_ep_idx;
      end
      if (done_pulse) cap_valid <= !seq_end;
    end
  end
endmodule

// File: rtl/ep_irq_clear_seq.sv
module ep_irq_clear_seq
  import ep_irq_pkg::*;
#(
  parameter int unsigned NUM_LOGICAL = 16,
  parameter int unsigned NUM_EP      = 2 * NUM_LOGICAL,
  parameter int unsigned IDX_W       = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EP-1:0] ep_event,
  input  logic              en_wr,
  input  logic [NUM_EP-1:0] en_wdata,
  input  logic              clr_wr,
  input  logic [NUM_EP-1:0] clr_wdata,
  output logic [NUM_EP-1:0] clr_rdata,
  output logic              sie_req,
  output logic [IDX_W-1:0]  sie_ep_idx,
  input  logic              sie_ack,
  input  logic [7:0]        sie_status,
  output logic [NUM_EP-1:0] ep_int_en,
  output logic [NUM_EP-1:0] irq_status,
  output logic [NUM_EP-1:0] dma_req_status,
  output logic              cmd_data_full,
  output logic [7:0]        cmd_data,
  output logic              irq_out
);
  logic [NUM_EP-1:0] pending;
  logic              any_pending;
  logic [IDX_W-1:0]  low_idx;
  logic              last_one;
  logic              done_pulse;
  logic [NUM_EP-1:0] done_vec;
  logic              wr_nonzero;

  assign wr_nonzero = clr_wr && (|clr_wdata);
  assign done_vec   = done_pulse ? (NUM_EP'(1) << sie_ep_idx) : '0;
  assign clr_rdata  = '0;
  assign irq_out    = |irq_status;

  ep_irq_status_regs #(.NUM_EP(NUM_EP)) u_regs (
    .clk(clk), .rst_n(rst_n), .ep_event(ep_event),
    .en_wr(en_wr), .en_wdata(en_wdata), .clr_vec(done_vec),
    .irq_status(irq_status), .dma_req_status(dma_req_status),
    .ep_int_en(ep_int_en)
  );

  ep_clr_pending #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .done_vec(done_vec), .pending(pending), .any_pending(any_pending),
    .low_idx(low_idx), .last_one(last_one)
  );

  ep_sie_cmd_fsm #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .any_pending(any_pending), .low_idx(low_idx),
    .last_one(last_one), .wr_nonzero(wr_nonzero), .sie_ack(sie_ack),
    .sie_status(sie_status), .sie_req(sie_req), .sie_ep_idx(sie_ep_idx),
    .done_pulse(done_pulse), .cmd_data_full(cmd_data_full),
    .cmd_data(cmd_data)
  );
endmodule

// File: rtl/ep_irq_clear_seq_chk.sv
module ep_irq_clear_seq_chk #(
  parameter int unsigned NUM_EP = 32,
  parameter int unsigned IDX_W  = $clog2(NUM_EP)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_EP-1:0] ep_event,
  input logic [NUM_EP-1:0] ep_int_en,
  input logic [NUM_EP-1:0] irq_status,
  input logic [NUM_EP-1:0] dma_req_status,
  input logic              clr_wr,
  input logic [NUM_EP-1:0] clr_wdata,
  input logic              sie_req,
  input logic              sie_ack,
  input logic [IDX_W-1:0]  sie_ep_idx,
  input logic              cmd_data_full,
  input logic [NUM_EP-1:0] pending
);
  function automatic logic [NUM_EP-1:0] below(input logic [IDX_W-1:0] k);
    logic [NUM_EP-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_EP; i++) if (i < int'(k)) m[i] = 1'b1;
    return m;
  endfunction

  AST_SLAVE_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irq_status & $past(ep_event & ep_int_en)) == $past(ep_event & ep_int_en))); // R1
  AST_DMA_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dma_req_status & $past(ep_event & ~ep_int_en)) == $past(ep_event & ~ep_int_en))); // R2
  AST_FLAG_DROPS_ON_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && (|clr_wdata)) |=> !cmd_data_full); // R5
  AST_FLAG_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    sie_req |-> !cmd_data_full); // R5
  AST_ACK_CLEARS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_req && sie_ack && !ep_event[sie_ep_idx]) |=> !irq_status[$past(sie_ep_idx)]); // R6
  AST_LOWEST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sie_req) && !$past(clr_wr)) |-> ((pending & below(sie_ep_idx)) == '0)); // R7
  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_req && sie_ack && ep_event[sie_ep_idx] && ep_int_en[sie_ep_idx])
      |=> irq_status[$past(sie_ep_idx)]); // R9
  AST_ZERO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(|clr_wdata) && !sie_req && cmd_data_full) |=> (cmd_data_full && !sie_req)); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (sie_req && !sie_ack) |=> (sie_req && $stable(sie_ep_idx))); // R11
endmodule

bind ep_irq_clear_seq ep_irq_clear_seq_chk #(.NUM_EP(NUM_EP), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ep_event(ep_event), .ep_int_en(ep_int_en),
  .irq_status(irq_status), .dma_req_status(dma_req_status),
  .clr_wr(clr_wr), .clr_wdata(clr_wdata), .sie_req(sie_req),
  .sie_ack(sie_ack), .sie_ep_idx(sie_ep_idx),
  .cmd_data_full(cmd_data_full), .pending(pending)
);

// File: tb/ep_irq_clear_seq_test.sv
`timescale 1ns/1ps
module ep_irq_clear_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_a = '0;
  logic [31:0] evt_b = '0;
  logic [31:0] ep_event;
  logic        en_wr = 1'b0;
  logic [31:0] en_wdata = '0;
  logic        clr_wr = 1'b0;
  logic [31:0] clr_wdata = '0;
  logic [31:0] clr_rdata;
  logic        sie_req;
  logic [4:0]  sie_ep_idx;
  logic        sie_ack = 1'b0;
  logic [7:0]  sie_status = '0;
  logic [31:0] ep_int_en, irq_status, dma_req_status;
  logic        cmd_data_full;
  logic [7:0]  cmd_data;
  logic        irq_out;

  int n_chk = 0;
  int n_fail = 0;
  int log_idx [0:63];
  int log_n = 0;
  logic [31:0] ack_evt_mask = '0;

  assign ep_event = evt_a | evt_b;
  always #10 clk = ~clk;

  ep_irq_clear_seq uut (
    .clk(clk), .rst_n(rst_n), .ep_event(ep_event), .en_wr(en_wr),
    .en_wdata(en_wdata), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .clr_rdata(clr_rdata), .sie_req(sie_req), .sie_ep_idx(sie_ep_idx),
    .sie_ack(sie_ack), .sie_status(sie_status), .ep_int_en(ep_int_en),
    .irq_status(irq_status), .dma_req_status(dma_req_status),
    .cmd_data_full(cmd_data_full), .cmd_data(cmd_data), .irq_out(irq_out)
  );

  function automatic logic [7:0] stat_of(input int i);
    return 8'h80 | 8'((i * 5) & 8'h7f);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // acknowledge responder with two cycles of latency
  initial begin
    forever begin
      @(negedge clk);
      if (sie_req && !sie_ack) begin
        @(negedge clk);
        @(negedge clk);
        log_idx[log_n] = int'(sie_ep_idx);
        log_n++;
        sie_status = stat_of(int'(sie_ep_idx));
        evt_b      = ack_evt_mask;
        sie_ack    = 1'b1;
        @(negedge clk);
        sie_ack = 1'b0;
        evt_b   = '0;
      end
    end
  end

  task automatic pulse_event(input logic [31:0] m);
    @(negedge clk); evt_a = m;
    @(negedge clk); evt_a = '0;
  endtask

  task automatic write_en(input logic [31:0] m);
    @(negedge clk); en_wr = 1'b1; en_wdata = m;
    @(negedge clk); en_wr = 1'b0;
  endtask

  task automatic write_clr(input logic [31:0] m);
    @(negedge clk); clr_wr = 1'b1; clr_wdata = m;
    @(negedge clk); clr_wr = 1'b0; clr_wdata = '0;
  endtask

  task automatic wait_done();
    int t = 0;
    while (!(cmd_data_full && !sie_req && !sie_ack) && t < 500) begin
      @(negedge clk); t++;
    end
    chk(t < 500, "R5 completion", 32'(t), 32'd500);
  endtask

  task automatic t_reset();
    chk(ep_int_en == 0, "R3 enable reset", ep_int_en, 0);
    chk(irq_status == 0 && dma_req_status == 0, "R3 status reset", irq_status | dma_req_status, 0);
    chk(!cmd_data_full && !sie_req, "R3 flag/req reset", {cmd_data_full, sie_req}, 0);
    chk(clr_rdata == 0, "R3 clear reads zero", clr_rdata, 0);
  endtask

  task automatic t_steer();
    write_en(32'h0000_00F0);
    chk(ep_int_en == 32'h0000_00F0, "R3 enable load", ep_int_en, 32'h0000_00F0);
    pulse_event(32'h0000_0033);
    chk(irq_status == 32'h0000_0030, "R1 slave routing", irq_status, 32'h0000_0030);
    chk(dma_req_status == 32'h0000_0003, "R2 dma routing", dma_req_status, 32'h0000_0003);
    chk(irq_out == 1'b1, "R10 irq set", 32'(irq_out), 1);
  endtask

  task automatic t_single();
    log_n = 0;
    write_clr(32'h0000_0020);
    chk(!cmd_data_full, "R5 flag dropped", 32'(cmd_data_full), 0);
    wait_done();
    chk(log_n == 1 && log_idx[0] == 5, "R4 one request idx 5", 32'(log_idx[0]), 5);
    chk(irq_status == 32'h0000_0010, "R6 bit cleared", irq_status, 32'h0000_0010);
    chk(cmd_data == stat_of(5), "R6 status byte", 32'(cmd_data), 32'(stat_of(5)));
  endtask

  task automatic t_zero_write();
    log_n = 0;
    write_clr(32'h0);
    repeat (4) @(negedge clk);
    chk(cmd_data_full && log_n == 0, "R4 zero write ignored", {31'(log_n), cmd_data_full}, 1);
    chk(irq_status == 32'h0000_0010, "R4 status untouched", irq_status, 32'h0000_0010);
  endtask

  task automatic t_multi();
    log_n = 0;
    pulse_event(32'h0000_00C0);
    write_clr(32'h0000_00D0);
    wait_done();
    chk(log_n == 3 && log_idx[0] == 4 && log_idx[1] == 6 && log_idx[2] == 7,
        "R7 ascending order", 32'(log_idx[0] * 256 + log_idx[1] * 16 + log_idx[2]), 32'h467);
    chk(cmd_data == stat_of(4), "R7 lowest status kept", 32'(cmd_data), 32'(stat_of(4)));
    chk(irq_out == 1'b0 && irq_status == 0, "R10 irq clear", irq_status, 0);
  endtask

  task automatic t_merge();
    int t = 0;
    log_n = 0;
    write_en(32'hFFFF_FFFF);
    pulse_event(32'h0010_0408);
    write_clr(32'h0010_0400);
    while (!(sie_req && sie_ep_idx == 5'd10) && t < 100) begin
      @(negedge clk); t++;
    end
    clr_wr = 1'b1; clr_wdata = 32'h0000_0008;
    @(negedge clk); clr_wr = 1'b0; clr_wdata = '0;
    chk(!cmd_data_full, "R8 flag low during merge", 32'(cmd_data_full), 0);
    wait_done();
    chk(log_n == 3 && log_idx[0] == 10 && log_idx[1] == 3 && log_idx[2] == 20,
        "R8 merged order", 32'(log_idx[0] * 4096 + log_idx[1] * 64 + log_idx[2]), 32'(10 * 4096 + 3 * 64 + 20));
    chk(cmd_data == stat_of(3), "R8 lowest of sequence", 32'(cmd_data), 32'(stat_of(3)));
    chk(irq_status == 0, "R8 all cleared", irq_status, 0);
  endtask

  task automatic t_event_wins();
    log_n = 0;
    pulse_event(32'h0000_1000);
    ack_evt_mask = 32'h0000_1000;
    write_clr(32'h0000_1000);
    wait_done();
    ack_evt_mask = '0;
    chk(irq_status == 32'h0000_1000, "R9 event kept", irq_status, 32'h0000_1000);
    chk(cmd_data == stat_of(12), "R9 status byte", 32'(cmd_data), 32'(stat_of(12)));
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_steer();
    t_single();
    t_zero_write();
    t_multi();
    t_merge();
    t_event_wins();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule